// File: doc/BRIEF.md
# Task Run Status Tracker

This block records which one of eight hardware tasks is executing at a given moment. It shows that as a read-only 16-bit status word in which at most one run flag is set. A dispatcher raises start requests, one line per task. When the tracker is idle it launches the lowest-numbered waiting request. Requests that arrive while a task is running wait in a pending latch kept for each task.

A completion pulse from the running task clears its run flag. On the same clock edge it raises a one-cycle interrupt pulse on that task's own interrupt line. A soft-reset strobe from the host stops the running task and discards every waiting request without raising any interrupt. A soft reset that arrives in the same cycle as a completion wins, so no interrupt is raised.

The control is a two-state machine:
- **ST_IDLE**: no flag is set.
- **ST_RUN**: exactly one flag is set.

It has four named transitions:
- **T_LAUNCH** (ST_IDLE to ST_RUN): something is pending and no soft reset is present.
- **T_COMPLETE** (ST_RUN to ST_IDLE): a completion pulse arrives and no soft reset is present.
- **T_ABORT** (ST_RUN to ST_IDLE): a soft reset arrives.
- **T_HOLD**: the machine stays where it is in every other case.

Top module: `task_run_tracker`

## Requirements
- R1: After synchronous reset, the status word reads 0, all interrupt outputs are 0 and no pending request is kept. With no new request, no task starts after reset.
- R2: Status bit i (i = 0..7) is the run flag of task i+1, driven by start_req[i]. At most one of bits 7..0 is 1 at any time.
- R3: While idle, a request seen on start_req[i] at a clock edge sets status bit i from that edge on.
- R4: A done_pulse while a task runs clears its flag. On the same edge it sets irq_out[i] for that task i, high for exactly one cycle.
- R5: An abort_wr strobe clears the running flag with no interrupt. It also discards every pending request, including one arriving in the same cycle, so none of them starts later.
- R6: Start requests that arrive while a task runs are held. They do not disturb the running flag, and they start after it ends.
- R7: When several requests are pending or arrive together while idle, the lowest index starts first.
- R8: A done_pulse while no task runs is ignored: no interrupt is raised and the status is unchanged.
- R9: When abort_wr and done_pulse arrive in the same cycle, no interrupt is raised and the flag is cleared.
- R10: Status bits 15..8 always read 0.
- R11: After a completion, a pending task's flag is set one cycle after the previous flag clears. That one cycle is spent idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 8 | Start request per task, bit i is task i+1 |
| done_pulse | input | 1 | Running task has completed |
| abort_wr | input | 1 | Host soft-reset write strobe |
| status_rd | output | 16 | Run status word, bits 7..0 one-hot or zero |
| irq_out | output | 8 | Completion interrupt pulse per task |

## Verification
Single requests on the edge tasks (bit 0 and bit 7) and on middle tasks check that each flag maps to its own bit and that the interrupt lands on the same line. Simultaneous and queued requests with mixed indices separate lowest-first order from arrival order. A request held while a task runs shows that waiting work neither disturbs the running flag nor is lost. Completion pulses while idle, soft resets with pending work, and soft reset together with completion tell a true completion apart from an abort, and show whether pending requests survive a soft reset.

// File: rtl/trt_pkg.sv
package trt_pkg;
    localparam int unsigned NUM_TASKS = 8;
    localparam int unsigned STAT_W    = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } trt_state_e;
endpackage

// File: rtl/trt_pick.sv
module trt_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            assign seen[i+1] = seen[i] | req[i];
            assign gnt[i]    = req[i] & ~seen[i];
        end
    endgenerate

    assign any = seen[N];
endmodule

// File: rtl/trt_pending.sv
module trt_pending #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] start_req,
    input  logic         clr_all,
    input  logic [N-1:0] consume,
    output logic [N-1:0] pend_all
);
    logic [N-1:0] pend_q;
    logic [N-1:0] pend_d;

    assign pend_all = pend_q | start_req;

    always_comb begin
        if (clr_all) begin
            pend_d = '0;
        end else begin
            pend_d = pend_all & ~consume;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    // R5: a soft reset leaves nothing waiting
    assert_abort_clears_pending_R5: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (pend_q == '0));
endmodule

// File: rtl/trt_fsm.sv
module trt_fsm
    import trt_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cand,
    input  logic         cand_any,
    input  logic         done,
    input  logic         abort,
    output logic [N-1:0] run_q,
    output logic         launch,
    output logic         done_hit
);
    trt_state_e state_q;
    trt_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        launch   = 1'b0;
        done_hit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!abort && cand_any) begin
                    launch  = 1'b1;      // T_LAUNCH
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (abort) begin
                    state_d = ST_IDLE;   // T_ABORT
                end else if (done) begin
                    done_hit = 1'b1;     // T_COMPLETE
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: run_q <= launch ? cand : '0;
                ST_RUN:  run_q <= (abort || done) ? '0 : run_q;
                default: run_q <= '0;
            endcase
        end
    end

    // R2: never more than one run flag
    assert_flags_onehot0_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(run_q));

    // R2: state and flags agree
    assert_run_has_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> $onehot(run_q));

    // R5: soft reset empties the flags on the next edge
    assert_abort_clears_flag_R5: assert property (@(posedge clk) disable iff (rst)
        abort |=> (run_q == '0));

    // R3: an idle launch sets exactly one flag
    assert_launch_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        launch |=> $onehot(run_q));
endmodule

// File: rtl/trt_irq.sv
module trt_irq #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fire,
    input  logic [N-1:0] who,
    output logic [N-1:0] irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= fire ? who : '0;
        end
    end

    // R4: one line at a time, one cycle long
    assert_irq_onehot0_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_q));

    assert_irq_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_q != '0) |=> (irq_q == '0));
endmodule

// File: rtl/task_run_tracker.sv
module task_run_tracker
    import trt_pkg::*;
#(
    parameter int unsigned N      = NUM_TASKS,
    parameter int unsigned STATUS = STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      start_req,
    input  logic              done_pulse,
    input  logic              abort_wr,
    output logic [STATUS-1:0] status_rd,
    output logic [N-1:0]      irq_out
);
    localparam int unsigned RSV_W = STATUS - N;

    logic [N-1:0] pend_all;
    logic [N-1:0] gnt;
    logic         gnt_any;
    logic [N-1:0] run_q;
    logic         launch;
    logic         done_hit;
    logic [N-1:0] consume;

    assign consume = gnt & {N{launch}};

    trt_pending #(.N(N)) i_pending (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .clr_all   (abort_wr),
        .consume   (consume),
        .pend_all  (pend_all)
    );

    trt_pick #(.N(N)) i_pick (
        .req (pend_all),
        .gnt (gnt),
        .any (gnt_any)
    );

    trt_fsm #(.N(N)) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .cand     (gnt),
        .cand_any (gnt_any),
        .done     (done_pulse),
        .abort    (abort_wr),
        .run_q    (run_q),
        .launch   (launch),
        .done_hit (done_hit)
    );

    trt_irq #(.N(N)) i_irq (
        .clk   (clk),
        .rst   (rst),
        .fire  (done_hit),
        .who   (run_q),
        .irq_q (irq_out)
    );

    assign status_rd = {{RSV_W{1'b0}}, run_q};

    // R4: completion clears the flag and raises an interrupt on the same edge
    assert_complete_irq_R4: assert property (@(posedge clk) disable iff (rst)
        done_hit |=> ((irq_out != '0) && (status_rd[N-1:0] == '0)));

    // R8: completion while idle raises nothing
    assert_idle_done_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && (run_q == '0)) |=> (irq_out == '0));

    // R9: soft reset silences completion
    assert_abort_no_irq_R9: assert property (@(posedge clk) disable iff (rst)
        abort_wr |=> (irq_out == '0));
endmodule

// File: tb/test_task_run_tracker.sv
module test_task_run_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  start_req = '0;
    logic        done_pulse = 1'b0;
    logic        abort_wr = 1'b0;
    logic [15:0] status_rd;
    logic [7:0]  irq_out;

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_st_q [$];
    logic [7:0]  exp_irq_q [$];
    string       tag_q [$];

    // reference state
    int          m_run = -1;
    logic [7:0]  m_pend = '0;

    always #5 clk = ~clk;

    task_run_tracker i_task_run_tracker (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .done_pulse (done_pulse),
        .abort_wr   (abort_wr),
        .status_rd  (status_rd),
        .irq_out    (irq_out)
    );

    task automatic compare(input string tag, input logic [15:0] es, input logic [7:0] ei);
        checks++;
        if (status_rd !== es || irq_out !== ei) begin
            fails++;
            $display("FAIL %s: status=%h irq=%h expected status=%h irq=%h",
                     tag, status_rd, irq_out, es, ei);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_st_q.size() > 0) begin
            compare(tag_q.pop_front(), exp_st_q.pop_front(), exp_irq_q.pop_front());
        end
    end

    // driver: one cycle of stimulus plus the expected result after the edge
    task automatic step(input logic [7:0] st, input logic dn, input logic ab, input string tag);
        logic [7:0]  ei;
        logic [7:0]  p;
        logic [15:0] es;
        start_req  = st;
        done_pulse = dn;
        abort_wr   = ab;
        ei = '0;
        if (ab) begin
            m_run  = -1;
            m_pend = '0;
        end else if (m_run >= 0) begin
            if (dn) begin
                ei = 8'(1 << m_run);
                m_run = -1;
            end
            m_pend = m_pend | st;
        end else begin
            p = m_pend | st;
            for (int k = 7; k >= 0; k--) begin
                if (p[k]) m_run = k;
            end
            if (m_run >= 0) p[m_run] = 1'b0;
            m_pend = p;
        end
        es = (m_run >= 0) ? 16'(1 << m_run) : 16'h0000;
        @(posedge clk);
        exp_st_q.push_back(es);
        exp_irq_q.push_back(ei);
        tag_q.push_back(tag);
        #1;
        start_req  = '0;
        done_pulse = 1'b0;
        abort_wr   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        start_req = '0; done_pulse = 1'b0; abort_wr = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        m_run = -1;
        m_pend = '0;
    endtask

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        compare("R1 reset state", 16'h0000, 8'h00);

        // R3 launch, R10 upper bits zero
        step(8'h04, 0, 0, "R3 start task3");
        step(8'h00, 0, 0, "R10 hold");
        // R4 completion and single-cycle pulse
        step(8'h00, 1, 0, "R4 complete task3");
        step(8'h00, 0, 0, "R4 pulse ends");
        // R8 done while idle
        step(8'h00, 1, 0, "R8 idle done");
        step(8'h00, 0, 0, "R8 after");

        // R2 edge bits
        step(8'h01, 0, 0, "R2 task1 bit0");
        step(8'h00, 1, 0, "R2 task1 irq");
        step(8'h80, 0, 0, "R2 task8 bit7");
        step(8'h00, 1, 0, "R2 task8 irq");

        // R6 hold while running, R7 order, R11 one idle cycle
        step(8'h20, 0, 0, "R6 start task6");
        step(8'h42, 0, 0, "R6 requests held");
        step(8'h00, 0, 0, "R6 still task6");
        step(8'h00, 1, 0, "R6 complete task6");
        step(8'h00, 0, 0, "R11 next launch after idle");
        step(8'h00, 1, 0, "R7 complete lower first");
        step(8'h00, 0, 0, "R7 higher follows");
        step(8'h00, 1, 0, "R7 complete higher");
        step(8'h00, 0, 0, "R7 idle");

        // R7 simultaneous requests
        step(8'h88, 0, 0, "R7 simultaneous");
        step(8'h00, 1, 0, "R7 complete task4");
        step(8'h00, 0, 0, "R7 task8 follows");

        // R5 abort with pending work
        step(8'h05, 0, 0, "R5 queue while running");
        step(8'h00, 0, 1, "R5 abort");
        step(8'h00, 0, 0, "R5 nothing resumes");
        step(8'h00, 0, 0, "R5 still idle");
        // R5 request in the abort cycle is dropped
        step(8'h10, 0, 1, "R5 abort drops request");
        step(8'h00, 0, 0, "R5 idle after drop");

        // R9 abort and done together
        step(8'h02, 0, 0, "R9 start task2");
        step(8'h00, 1, 1, "R9 abort wins");
        step(8'h00, 0, 0, "R9 no late irq");

        // R1 reset mid-run clears pending
        step(8'h40, 0, 0, "R1 start task7");
        step(8'h01, 0, 0, "R1 queue task1");
        repeat (2) @(negedge clk);
        do_reset();
        step(8'h00, 0, 0, "R1 nothing after reset");
        step(8'h00, 0, 0, "R1 still idle");

        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule